// File: doc/BRIEF.md
# Cascadable Serial LMS Adaptive FIR Filter

This block is an adaptive transversal filter whose tap line holds four-level line symbols. For each symbol strobe it shifts one symbol into its delay line. One shared multiply-accumulate datapath then walks the taps in turn. At the end it produces a saturated filter output and a one-cycle valid pulse. In the same serial pass it adapts each coefficient with the least-mean-squares rule. The rule uses an error value that the surrounding receiver supplies with the strobe. That error belongs to the output of the previous symbol, so the update uses the tap contents from before the shift.

A mode input picks the source of the tap line. As an echo canceller it takes the locally transmitted symbol. As a decision-feedback equalizer it takes the sliced past decision. Several instances can be chained into a longer filter. The oldest tap symbol leaves on a symbol output that feeds the next instance's delay line. A combinational partial-sum path adds the upstream instance's sum into this instance's sum.

Top module: `adapt_fir_cascade`

## Requirements
- R1: A synchronous active-high reset clears every coefficient and every delay-line entry to zero, and drives y_vld low and y_out to zero.
- R2: A symbol port carries a 3-bit code. Bit 2 high means a symbol is present, and bit 2 low means the value zero. Bit 1 high makes the value negative. Bit 0 selects magnitude 3 when high and 1 when low. So code 5 is +3, 7 is -3, 4 is +1, 6 is -1, and codes 0 to 3 are zero.
- R3: A strobe sampled at clock edge n while the block is idle makes y_vld high for exactly one cycle, the cycle after edge n+NTAPS+1.
- R4: A strobe that arrives while a pass is running, or in the cycle that ends it, is ignored. The delay line is not shifted and no extra valid pulse appears.
- R5: At the valid pulse, y_out is the sum of coef[k]*x[k] over all taps plus casc_in, saturated to a signed OW-bit value. Here x is the tap line after this strobe's shift, and the coefficients are those held before this pass's update.
- R6: casc_out is the same total saturated to a signed AW-bit value. It is valid from the valid pulse until the next accepted strobe, and it follows casc_in combinationally.
- R7: With dfe_mode low at the strobe, tx_sym enters tap 0. With dfe_mode high, dec_sym enters tap 0.
- R8: When adaptation is on, every coefficient k changes during the pass by (err*p[k]) arithmetically shifted right by mu_shift, where p is the tap line before the shift. err, mu_shift and adapt_en are sampled with the strobe.
- R9: When adapt_en is low at the strobe, no coefficient changes during that pass.
- R10: A coefficient update saturates at the signed CW-bit limits and does not wrap.
- R11: The filter output saturates at the signed OW-bit limits.
- R12: sym_out shows the code at tap NTAPS-1 and changes only when a strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | One-cycle symbol strobe |
| dfe_mode | input | 1 | 0 selects tx_sym, 1 selects dec_sym |
| tx_sym | input | 3 | Transmitted symbol code (echo-canceller source) |
| dec_sym | input | 3 | Sliced decision code (equalizer source) |
| err_in | input | EW | Signed error for the previous output |
| mu_shift | input | MUW | Step size as a right-shift count |
| adapt_en | input | 1 | Enables coefficient adaptation |
| casc_in | input | AW | Signed partial sum from the upstream instance |
| casc_out | output | AW | Signed saturated sum of this instance plus casc_in |
| sym_out | output | 3 | Code at the oldest tap, for the next instance |
| y_out | output | OW | Saturated filter output |
| y_vld | output | 1 | One-cycle output-valid pulse |

## Verification
The first symbols after reset carry no adaptation, so an all-zero output shows that coefficients and taps start cleared. A long run of pseudo-random codes then follows. It mixes absent symbols, both modes with different values on the two symbol ports, random errors and cascade inputs. This run separates a wrong tap-source choice, a wrong previous-versus-current tap in the update, and a wrong shift direction. A frozen run with adaptation off shows that no coefficient moves. Strobes injected mid-pass and in the final cycle must leave the line and the pulse timing unchanged. Runs of +3 symbols with the largest positive and negative errors at zero shift drive the coefficients, the output and the cascade sum into their limits. Wrap-around, as opposed to clamping, shows up there.

// File: rtl/lms_fir_pkg.sv
package lms_fir_pkg;

    typedef struct packed {
        logic present;
        logic neg;
        logic big;
    } sym_code_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    // Clamp a wide signed value into a signed range of w bits.
    function automatic logic signed [63:0] clamp_w(input logic signed [63:0] v,
                                                   input int unsigned w);
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -hi - 64'sd1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // Multiply by a four-level symbol with a shift and an add only.
    function automatic logic signed [63:0] scale_by_sym(input logic signed [63:0] v,
                                                        input sym_code_t s);
        logic signed [63:0] m;
        if (!s.present) return '0;
        m = s.big ? ((v <<< 1) + v) : v;
        return s.neg ? -m : m;
    endfunction

endpackage

// File: rtl/lms_seq.sv
module lms_seq #(
    parameter int NTAPS = 64,
    localparam int IW = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sym_stb,
    output logic          start,
    output logic          run,
    output logic          done,
    output logic [IW-1:0] idx
);
    import lms_fir_pkg::*;

    phase_t ph;

    assign start = sym_stb && (ph == PH_IDLE);
    assign run   = (ph == PH_RUN);
    assign done  = (ph == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            idx <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (sym_stb) begin
                    ph  <= PH_RUN;
                    idx <= '0;
                end
                PH_RUN: begin
                    if (idx == IW'(NTAPS - 1)) ph <= PH_DONE;
                    else idx <= idx + IW'(1);
                end
                PH_DONE: ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    AST_RUN_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (idx == '0));  // R3
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(run) && $past(idx) == IW'(NTAPS - 1)));  // R3

endmodule

// File: rtl/lms_tapline.sv
module lms_tapline #(
    parameter int NTAPS = 64,
    localparam int IW = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift,
    input  logic          busy,
    input  logic          dfe_mode,
    input  logic [2:0]    tx_sym,
    input  logic [2:0]    dec_sym,
    input  logic [IW-1:0] idx,
    output logic [2:0]    cur_tap,
    output logic [2:0]    prev_tap,
    output logic [2:0]    oldest
);
    // Entry 0..NTAPS-1 are the live taps; entry NTAPS keeps the symbol
    // pushed out so that the previous line is still visible as 1..NTAPS.
    logic [NTAPS:0][2:0] line;
    logic [IW:0]         cidx;
    logic [IW:0]         pidx;
    logic [2:0]          pick;

    assign pick     = dfe_mode ? dec_sym : tx_sym;
    assign cidx     = {1'b0, idx};
    assign pidx     = cidx + (IW + 1)'(1);
    assign cur_tap  = line[cidx];
    assign prev_tap = line[pidx];
    assign oldest   = line[NTAPS-1];

    always_ff @(posedge clk) begin
        if (rst) line <= '0;
        else if (shift) line <= {line[NTAPS-1:0], pick};
    end

    AST_LINE_STILL: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(line));  // R4

endmodule

// File: rtl/lms_coefbank.sv
module lms_coefbank #(
    parameter int NTAPS = 64,
    parameter int CW    = 16,
    parameter int EW    = 16,
    parameter int MUW   = 4,
    localparam int IW = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 run,
    input  logic [IW-1:0]        idx,
    input  logic signed [EW-1:0] err_in,
    input  logic [MUW-1:0]       mu_in,
    input  logic                 adapt_in,
    input  logic [2:0]           prev_tap,
    output logic signed [CW-1:0] coef_rd
);
    import lms_fir_pkg::*;

    logic [NTAPS-1:0][CW-1:0] coef;
    logic signed [EW-1:0]     err_q;
    logic [MUW-1:0]           mu_q;
    logic                     adapt_q;
    logic signed [63:0]       step64;
    logic signed [63:0]       sum64;
    logic signed [63:0]       sat64;

    assign coef_rd = coef[idx];

    always_comb begin
        step64 = scale_by_sym(64'(err_q), sym_code_t'(prev_tap)) >>> mu_q;
        sum64  = 64'(coef_rd) + step64;
        sat64  = clamp_w(sum64, CW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            coef    <= '0;
            err_q   <= '0;
            mu_q    <= '0;
            adapt_q <= 1'b0;
        end else begin
            if (start) begin
                err_q   <= err_in;
                mu_q    <= mu_in;
                adapt_q <= adapt_in;
            end
            if (run && adapt_q) coef[idx] <= sat64[CW-1:0];
        end
    end

    AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !adapt_q |=> $stable(coef));  // R9

endmodule

// File: rtl/lms_accum.sv
module lms_accum #(
    parameter int CW = 16,
    parameter int AW = 24,
    parameter int OW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 run,
    input  logic                 done,
    input  logic signed [CW-1:0] coef_rd,
    input  logic [2:0]           cur_tap,
    input  logic signed [AW-1:0] casc_in,
    output logic signed [AW-1:0] casc_out,
    output logic signed [OW-1:0] y_out,
    output logic                 y_vld
);
    import lms_fir_pkg::*;

    logic signed [AW-1:0] acc;
    logic signed [63:0]   acc_nx64;
    logic signed [63:0]   total64;
    logic signed [63:0]   co64;
    logic signed [63:0]   y64;

    always_comb begin
        acc_nx64 = 64'(acc) + scale_by_sym(64'(coef_rd), sym_code_t'(cur_tap));
        total64  = 64'(acc) + 64'(casc_in);
        co64     = clamp_w(total64, AW);
        y64      = clamp_w(total64, OW);
    end

    assign casc_out = co64[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            y_out <= '0;
            y_vld <= 1'b0;
        end else begin
            y_vld <= done;
            if (start) acc <= '0;
            else if (run) acc <= acc_nx64[AW-1:0];
            if (done) y_out <= y64[OW-1:0];
        end
    end

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        start |=> (acc == '0));  // R5
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        y_vld |=> !y_vld);  // R3

endmodule

// File: rtl/adapt_fir_cascade.sv
module adapt_fir_cascade #(
    parameter int NTAPS = 64,
    parameter int CW    = 16,
    parameter int AW    = 24,
    parameter int EW    = 16,
    parameter int OW    = 16,
    parameter int MUW   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sym_stb,
    input  logic                 dfe_mode,
    input  logic [2:0]           tx_sym,
    input  logic [2:0]           dec_sym,
    input  logic signed [EW-1:0] err_in,
    input  logic [MUW-1:0]       mu_shift,
    input  logic                 adapt_en,
    input  logic signed [AW-1:0] casc_in,
    output logic signed [AW-1:0] casc_out,
    output logic [2:0]           sym_out,
    output logic signed [OW-1:0] y_out,
    output logic                 y_vld
);
    localparam int IW = (NTAPS > 1) ? $clog2(NTAPS) : 1;

    logic                 start;
    logic                 run;
    logic                 done;
    logic [IW-1:0]        idx;
    logic [2:0]           cur_tap;
    logic [2:0]           prev_tap;
    logic signed [CW-1:0] coef_rd;

    lms_seq #(.NTAPS(NTAPS)) u_seq (
        .clk(clk), .rst(rst), .sym_stb(sym_stb),
        .start(start), .run(run), .done(done), .idx(idx)
    );

    lms_tapline #(.NTAPS(NTAPS)) u_line (
        .clk(clk), .rst(rst), .shift(start), .busy(run || done),
        .dfe_mode(dfe_mode), .tx_sym(tx_sym), .dec_sym(dec_sym), .idx(idx),
        .cur_tap(cur_tap), .prev_tap(prev_tap), .oldest(sym_out)
    );

    lms_coefbank #(.NTAPS(NTAPS), .CW(CW), .EW(EW), .MUW(MUW)) u_coef (
        .clk(clk), .rst(rst), .start(start), .run(run), .idx(idx),
        .err_in(err_in), .mu_in(mu_shift), .adapt_in(adapt_en),
        .prev_tap(prev_tap), .coef_rd(coef_rd)
    );

    lms_accum #(.CW(CW), .AW(AW), .OW(OW)) u_acc (
        .clk(clk), .rst(rst), .start(start), .run(run), .done(done),
        .coef_rd(coef_rd), .cur_tap(cur_tap), .casc_in(casc_in),
        .casc_out(casc_out), .y_out(y_out), .y_vld(y_vld)
    );

endmodule

// File: tb/test_adapt_fir_cascade.sv
module test_adapt_fir_cascade;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 64;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic               rst;
    logic               sym_stb;
    logic               dfe_mode;
    logic [2:0]         tx_sym;
    logic [2:0]         dec_sym;
    logic signed [15:0] err_in;
    logic [3:0]         mu_shift;
    logic               adapt_en;
    logic signed [23:0] casc_in;
    logic signed [23:0] casc_out;
    logic [2:0]         sym_out;
    logic signed [15:0] y_out;
    logic               y_vld;

    adapt_fir_cascade i_adapt_fir_cascade (
        .clk(clk), .rst(rst), .sym_stb(sym_stb), .dfe_mode(dfe_mode),
        .tx_sym(tx_sym), .dec_sym(dec_sym), .err_in(err_in), .mu_shift(mu_shift),
        .adapt_en(adapt_en), .casc_in(casc_in), .casc_out(casc_out),
        .sym_out(sym_out), .y_out(y_out), .y_vld(y_vld)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int coef_m[NT];
    int line_m[NT+1];
    int unsigned seed = 32'h1234_5678;

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 16);
    endfunction

    // R2: code to value
    function automatic int code_val(int c);
        int v;
        if ((c & 4) == 0) return 0;
        v = ((c & 1) != 0) ? 3 : 1;
        return ((c & 2) != 0) ? -v : v;
    endfunction

    function automatic longint clampw(longint v, int w);
        longint hi;
        hi = (longint'(1) <<< (w - 1)) - 1;
        if (v > hi) return hi;
        if (v < -hi - 1) return -hi - 1;
        return v;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NT; k++) coef_m[k] = 0;
        for (int k = 0; k <= NT; k++) line_m[k] = 0;
    endtask

    task automatic symbol(input int txc, input int decc, input int mode, input int e,
                          input int mu, input int ad, input longint cas, input bit poke);
        int prev[NT+1];
        longint sum;
        longint y_exp;
        longint co_exp;
        @(negedge clk);
        tx_sym = 3'(txc); dec_sym = 3'(decc); dfe_mode = mode[0];
        err_in = e[15:0]; mu_shift = mu[3:0]; adapt_en = ad[0];
        casc_in = cas[23:0]; sym_stb = 1'b1;
        prev = line_m;
        for (int k = NT; k > 0; k--) line_m[k] = line_m[k-1];
        line_m[0] = (mode != 0) ? decc : txc;  // R7
        sum = 0;
        for (int k = 0; k < NT; k++) sum += longint'(coef_m[k]) * code_val(line_m[k]);
        if (ad != 0)  // R8, R10
            for (int k = 0; k < NT; k++)
                coef_m[k] = int'(clampw(longint'(coef_m[k]) + ((e * code_val(prev[k])) >>> mu), 16));
        y_exp  = clampw(sum + cas, 16);
        co_exp = clampw(sum + cas, 24);
        @(negedge clk);
        sym_stb = 1'b0;
        check("R12", "sym_out", longint'(sym_out), longint'(line_m[NT-1]));
        for (int i = 0; i < 68; i++) begin
            check("R3", "y_vld", longint'(y_vld), (i == 65) ? 1 : 0);
            if (i == 65) check("R5/R11", "y_out", longint'(y_out), y_exp);
            if (i == 67) check("R6", "casc_out", longint'(casc_out), co_exp);
            if (poke && (i == 10 || i == 64)) begin
                sym_stb = 1'b1; tx_sym = ~tx_sym; dec_sym = ~dec_sym;
                err_in = ~err_in; adapt_en = ~adapt_en; dfe_mode = ~dfe_mode;
                mu_shift = ~mu_shift;
            end else if (poke && (i == 11 || i == 65)) begin
                sym_stb = 1'b0;
            end
            @(negedge clk);
        end
        if (poke) check("R4", "sym_out after ignored strobes", longint'(sym_out),
                        longint'(line_m[NT-1]));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sym_stb = 1'b0; dfe_mode = 1'b0; tx_sym = '0; dec_sym = '0;
        err_in = '0; mu_shift = '0; adapt_en = 1'b0; casc_in = '0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1", "y_vld in reset", longint'(y_vld), 0);
        check("R1", "y_out in reset", longint'(y_out), 0);
        check("R1", "sym_out in reset", longint'(sym_out), 0);
        check("R1", "casc_out in reset", longint'(casc_out), 0);
        rst = 1'b0;

        // R1: zero coefficients give zero output
        for (int s = 0; s < 3; s++) symbol(5, 7, 0, 1000, 0, 0, 0, 1'b0);

        // R2, R7, R8: mixed training run with both modes and all codes
        for (int s = 0; s < 110; s++) begin
            symbol(rnd() % 8, rnd() % 8, rnd() % 2, (rnd() % 65536) - 32768,
                   4 + rnd() % 4, 1, longint'((rnd() % 2001) - 1000), (s % 7) == 3);
        end

        // R9: frozen coefficients with large errors
        for (int s = 0; s < 20; s++)
            symbol(rnd() % 8, rnd() % 8, rnd() % 2, (rnd() % 65536) - 32768, 0, 0,
                   longint'((rnd() % 201) - 100), (s % 5) == 1);

        // R1: reset mid-stream clears the learned state
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1", "sym_out after reset", longint'(sym_out), 0);
        symbol(5, 5, 0, 0, 0, 0, 0, 1'b0);

        // R10, R11: positive saturation of coefficients and output
        for (int s = 0; s < 70; s++) symbol(5, 6, 0, 32767, 0, 1, 0, 1'b0);
        // R6: cascade sum clamps high
        symbol(5, 6, 0, 0, 0, 0, 64'sd8388000, 1'b0);

        // R10, R11: negative saturation
        for (int s = 0; s < 70; s++) symbol(5, 4, 0, -32768, 0, 1, 0, 1'b0);
        // R6: cascade sum clamps low
        symbol(5, 4, 0, 0, 0, 0, -64'sd8388000, 1'b0);

        // R7: equalizer mode with distinct port values
        for (int s = 0; s < 6; s++) symbol(0, 7 - s % 3, 1, 500, 3, 1, 0, 1'b1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule